// File: doc/BRIEF.md
# Byte Shift, Rotate and Swap Unit

This block is the single-operand bit-movement stage of an 8-bit datapath. Each cycle it takes one operand byte, the current carry flag and a 3-bit operation code. It returns the moved byte, the four status flags zero, carry, negative and overflow, and a write mask that tells the status register which of those flags to take.

The shifts move the byte by one place. Left moves fill bit 0, and right moves fill the top bit. The two rotates pass through the carry flag, so the bit that leaves the byte goes into carry and the old carry comes back in at the other end. Arithmetic right shift copies the sign bit down and leaves it in place. Nibble swap exchanges the two halves of the byte and touches no flag. The data width is a parameter that must be even.

An output register is chosen by a parameter and is on by default. When it is on, every result appears one clock after its inputs are applied.

Top module: `shrot_unit`

## Requirements
- R1: Code 0 (logical shift left) returns {operand[6:0], 0}, and flag_c equals the old operand bit 7.
- R2: Code 1 (logical shift right) returns {0, operand[7:1]}, and flag_c equals the old operand bit 0.
- R3: Code 2 (rotate left through carry) returns {operand[6:0], carry_in}, and flag_c equals the old operand bit 7.
- R4: Code 3 (rotate right through carry) returns {carry_in, operand[7:1]}, and flag_c equals the old operand bit 0.
- R5: Code 4 (arithmetic shift right) returns {operand[7], operand[7:1]}, and flag_c equals the old operand bit 0.
- R6: Code 5 (nibble swap) returns {operand[3:0], operand[7:4]}. flag_wr is 0, flag_c repeats carry_in, and flag_z, flag_n and flag_v are 0.
- R7: For codes 0 to 4, flag_z is 1 exactly when the result byte is zero, and flag_n equals result bit 7.
- R8: For codes 0 to 4, flag_v equals flag_n XOR flag_c.
- R9: For codes 0 to 4, flag_wr is 4'b1111. Bit 0 marks Z, bit 1 marks C, bit 2 marks N and bit 3 marks V.
- R10: Codes 6 and 7 return the operand unchanged. flag_wr is 0, flag_c repeats carry_in, and the other flags are 0.
- R11: With the output register on, results appear one clock after their inputs. While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code (0 to 7) |
| operand | input | 8 | Byte to be moved |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Moved byte |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| flag_wr | output | 4 | Flag write mask, bit order Z, C, N, V from bit 0 |

## Verification
The hardest cases are those where the incoming carry decides the result. One is a rotate of a zero byte with carry set, which must give a nonzero result with Z clear. Another is a rotate with carry clear that must give zero. The overflow flag must also be seen with N and C in all four combinations, for example an arithmetic shift of 0x80, which gives N=1 and C=0. Directed vectors reach these edges first. A full sweep then applies every code, every operand byte and both carry values back to back, so every fill-bit and flag combination appears at least once.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_LSL  = 3'd0,
      OP_LSR  = 3'd1,
      OP_ROL  = 3'd2,
      OP_ROR  = 3'd3,
      OP_ASR  = 3'd4,
      OP_SWAP = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } shrot_op_e;

   localparam int unsigned FLAG_CNT = 4;
   localparam int unsigned FLAG_Z   = 0;
   localparam int unsigned FLAG_C   = 1;
   localparam int unsigned FLAG_N   = 2;
   localparam int unsigned FLAG_V   = 3;

   typedef struct packed {
      logic v;
      logic n;
      logic c;
      logic z;
   } shrot_flags_t;

   function automatic logic op_sets_flags(shrot_op_e op);
      return (op == OP_LSL) || (op == OP_LSR) || (op == OP_ROL) ||
             (op == OP_ROR) || (op == OP_ASR);
   endfunction

endpackage

// File: rtl/shrot_datapath.sv
module shrot_datapath
   import shrot_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  shrot_op_e          op,
   input  logic [DATA_W-1:0]  operand,
   input  logic               carry_in,
   output logic [DATA_W-1:0]  result,
   output logic               carry_out
);

   localparam int unsigned MSB  = DATA_W - 1;
   localparam int unsigned HALF = DATA_W / 2;

   logic              left_fill;
   logic              right_fill;
   logic [DATA_W-1:0] left_mv;
   logic [DATA_W-1:0] right_mv;
   logic [DATA_W-1:0] swapped;

   // Fill bit for the vacated end of the byte
   assign left_fill = (op == OP_ROL) ? carry_in : 1'b0;

   always_comb begin
      unique case (op)
         OP_ROR:  right_fill = carry_in;
         OP_ASR:  right_fill = operand[MSB];
         default: right_fill = 1'b0;
      endcase
   end

   // Bit-level wiring of the one-place moves and the half swap
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == 0) begin : g_lo
         assign left_mv[i] = left_fill;
      end else begin : g_lo_mid
         assign left_mv[i] = operand[i-1];
      end
      if (i == MSB) begin : g_hi
         assign right_mv[i] = right_fill;
      end else begin : g_hi_mid
         assign right_mv[i] = operand[i+1];
      end
      assign swapped[i] = operand[(i + HALF) % DATA_W];
   end

   always_comb begin
      unique case (op)
         OP_LSL, OP_ROL: begin
            result    = left_mv;
            carry_out = operand[MSB];
         end
         OP_LSR, OP_ROR, OP_ASR: begin
            result    = right_mv;
            carry_out = operand[0];
         end
         OP_SWAP: begin
            result    = swapped;
            carry_out = carry_in;
         end
         default: begin
            result    = operand;
            carry_out = carry_in;
         end
      endcase
   end

endmodule

// File: rtl/shrot_flagcalc.sv
module shrot_flagcalc
   import shrot_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  shrot_op_e          op,
   input  logic [DATA_W-1:0]  result,
   input  logic               carry_out,
   output shrot_flags_t       flags,
   output logic [FLAG_CNT-1:0] wr_mask
);

   localparam int unsigned MSB = DATA_W - 1;

   logic upd;
   logic neg;

   assign upd = op_sets_flags(op);
   assign neg = result[MSB];

   always_comb begin
      flags   = '0;
      flags.c = carry_out;
      wr_mask = '0;
      if (upd) begin
         flags.z = (result == '0);
         flags.n = neg;
         flags.v = neg ^ carry_out;
         wr_mask = '1;
      end
   end

endmodule

// File: rtl/shrot_outstage.sv
module shrot_outstage #(
   parameter int unsigned WIDTH   = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_wire
      assign q = d;
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] operand,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_n,
   output logic              flag_v,
   output logic [3:0]        flag_wr
);

   localparam int unsigned MSB   = DATA_W - 1;
   localparam int unsigned PIPE_W = DATA_W + $bits(shrot_flags_t) + FLAG_CNT;

   if (DATA_W < 2)       begin : g_chk_w   $error("shrot_unit: DATA_W must be at least 2"); end
   if (DATA_W % 2 != 0)  begin : g_chk_ev  $error("shrot_unit: DATA_W must be even for the half swap"); end

   shrot_op_e                op;
   logic [DATA_W-1:0]        res_c;
   logic                     cout_c;
   shrot_flags_t             flg_c;
   logic [FLAG_CNT-1:0]      wr_c;
   logic [PIPE_W-1:0]        pipe_d;
   logic [PIPE_W-1:0]        pipe_q;
   shrot_flags_t             flg_q;

   assign op = shrot_op_e'(op_sel);

   shrot_datapath #(.DATA_W(DATA_W)) u_dp (
      .op        (op),
      .operand   (operand),
      .carry_in  (carry_in),
      .result    (res_c),
      .carry_out (cout_c)
   );

   shrot_flagcalc #(.DATA_W(DATA_W)) u_fl (
      .op        (op),
      .result    (res_c),
      .carry_out (cout_c),
      .flags     (flg_c),
      .wr_mask   (wr_c)
   );

   assign pipe_d = {res_c, flg_c, wr_c};

   shrot_outstage #(.WIDTH(PIPE_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pipe_d),
      .q     (pipe_q)
   );

   assign {result, flg_q, flag_wr} = pipe_q;
   assign flag_z = flg_q.z;
   assign flag_c = flg_q.c;
   assign flag_n = flg_q.n;
   assign flag_v = flg_q.v;

   if (OUT_REG) begin : g_props
      p_lsl_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 3'd0) |=> (flag_c == $past(operand[MSB])) && (result[0] == 1'b0));
      p_ror_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 3'd3) |=> (result[MSB] == $past(carry_in)) && (flag_c == $past(operand[0])));
      p_asr_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 3'd4) |=> (result[MSB] == $past(operand[MSB])));
      p_swap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel == 3'd5) |=> (flag_wr == 4'b0000) && (flag_c == $past(carry_in)));
      p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
         flag_wr[FLAG_Z] |-> (flag_z == (result == '0)) && (flag_n == result[MSB]));
      p_ovf_xor_r8: assert property (@(posedge clk) disable iff (!rst_n)
         flag_wr[FLAG_V] |-> (flag_v == (flag_n ^ flag_c)));
      p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel <= 3'd4) |=> (flag_wr == 4'b1111));
      p_rsv_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (op_sel >= 3'd6) |=> (result == $past(operand)) && (flag_wr == 4'b0000));
   end

endmodule

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;

   typedef struct {
      logic [7:0] res;
      logic       z, c, n, v;
      logic [3:0] wr;
      logic [2:0] op;
      logic [7:0] a;
      logic       ci;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_sel = '0;
   logic [7:0] operand = '0;
   logic       carry_in = 1'b0;
   logic [7:0] result;
   logic       flag_z, flag_c, flag_n, flag_v;
   logic [3:0] flag_wr;

   int checks = 0;
   int errors = 0;
   item_t sb[$];

   always #2.5 clk = ~clk;

   shrot_unit i_shrot_unit (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand),
      .carry_in(carry_in), .result(result), .flag_z(flag_z), .flag_c(flag_c),
      .flag_n(flag_n), .flag_v(flag_v), .flag_wr(flag_wr)
   );

   function automatic string op_req(logic [2:0] op);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         default: return "R10";
      endcase
   endfunction

   function automatic item_t model(logic [2:0] op, logic [7:0] a, logic ci);
      item_t e;
      e.op = op; e.a = a; e.ci = ci;
      e.z = 0; e.n = 0; e.v = 0; e.wr = 4'b0000; e.c = ci;
      case (op)
         3'd0: begin e.res = {a[6:0], 1'b0}; e.c = a[7]; end
         3'd1: begin e.res = {1'b0, a[7:1]}; e.c = a[0]; end
         3'd2: begin e.res = {a[6:0], ci};   e.c = a[7]; end
         3'd3: begin e.res = {ci, a[7:1]};   e.c = a[0]; end
         3'd4: begin e.res = {a[7], a[7:1]}; e.c = a[0]; end
         3'd5: e.res = {a[3:0], a[7:4]};
         default: e.res = a;
      endcase
      if (op <= 3'd4) begin
         e.z  = (e.res == 8'h00);
         e.n  = e.res[7];
         e.v  = e.n ^ e.c;
         e.wr = 4'b1111;
      end
      return e;
   endfunction

   task automatic drive(logic [2:0] op, logic [7:0] a, logic ci);
      @(negedge clk);
      op_sel = op; operand = a; carry_in = ci;
      sb.push_back(model(op, a, ci));
   endtask

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Monitor: one registered result per clock after each driven item
   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         item_t e;
         e = sb.pop_front();
         chk(op_req(e.op), "result", result, e.res);
         chk(op_req(e.op), "flag_c", flag_c, e.c);
         chk("R7", "flag_z", flag_z, e.z);
         chk("R7", "flag_n", flag_n, e.n);
         chk("R8", "flag_v", flag_v, e.v);
         chk((e.op <= 3'd4) ? "R9" : op_req(e.op), "flag_wr", flag_wr, e.wr);
      end
   end

   initial begin
      #(5ns * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R11: outputs held at zero during reset, even with live inputs
      op_sel = 3'd2; operand = 8'hFF; carry_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11", "reset result", result, 0);
      chk("R11", "reset flags", {flag_z, flag_c, flag_n, flag_v}, 0);
      chk("R11", "reset mask", flag_wr, 0);
      rst_n = 1'b1;
      // Directed corners
      drive(3'd0, 8'h80, 1'b0);  // R1: result zero, C=1, V=1
      drive(3'd0, 8'h40, 1'b1);  // R1: N=1, C=0
      drive(3'd1, 8'h01, 1'b1);  // R2: zero with carry out
      drive(3'd2, 8'h00, 1'b1);  // R3: carry enters bit 0
      drive(3'd2, 8'h80, 1'b0);  // R3: zero result, C=1
      drive(3'd3, 8'h00, 1'b1);  // R4: carry enters bit 7
      drive(3'd3, 8'h01, 1'b0);  // R4: zero result, C=1
      drive(3'd4, 8'h80, 1'b1);  // R5: sign kept, N=1 C=0 V=1
      drive(3'd4, 8'h81, 1'b0);  // R5: N=1 C=1 V=0
      drive(3'd5, 8'hA5, 1'b1);  // R6: swap, no flags
      drive(3'd5, 8'h00, 1'b0);  // R6: zero result, still no flags
      drive(3'd6, 8'h3C, 1'b1);  // R10
      drive(3'd7, 8'h00, 1'b0);  // R10
      // Full sweep of every code, operand and carry
      for (int op = 0; op < 8; op++)
         for (int a = 0; a < 256; a++)
            for (int ci = 0; ci < 2; ci++)
               drive(op[2:0], a[7:0], ci[0]);
      @(negedge clk);
      @(negedge clk);
      chk("R11", "scoreboard drained", sb.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule